// File: doc/BRIEF.md
# Processor trap entry controller

This block computes the state change a windowed-register RISC core makes when it accepts a trap. Every cycle it looks at the current status fields, the program counter pair, the trap base register and three kinds of request. These are a reset request, a synchronous (instruction-caused) trap with its type code, and a 4-bit external interrupt level. From these it decides whether a trap is taken and registers the resulting state.

A taken trap only makes reversible edits to the status fields. It clears the trap-enable bit, copies the supervisor bit into the previous-supervisor bit, and moves the window pointer down by one with wraparound. The interrupt mask is never touched. The old program counters, or the pair after them for an interrupt, are presented as the two values to save into the new window. The new program counter pair points into the vector table selected by the trap base register and the trap type.

If a synchronous trap arrives while traps are disabled, the core enters a sticky error mode. Only a reset trap leaves that mode. When no trap is taken, the status, counter and base outputs follow the inputs one cycle later.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A taken trap drives `et_o` to 0 in the cycle after the request.
- R2: A taken trap sets `ps_o` to the sampled `s_i` and leaves `s_o` equal to `s_i`.
- R3: A taken trap sets `cwp_o` to `cwp_i` minus one modulo 8, so window 0 becomes window 7.
- R4: The saved pair `save_pc_o`/`save_npc_o` is (`npc_i`, `npc_i`+4) for an interrupt and (`pc_i`, `npc_i`) for a synchronous or reset trap. When no trap is taken it holds its last value.
- R5: A taken trap sets `tbr_o` as follows: bits 31:12 are taken from `tbr_i`, bits 11:4 hold the trap type, and bits 3:0 are 0. The type is 0x00 for reset, `sync_tt_i` for a synchronous trap and 0x10 plus the level for an interrupt.
- R6: For a non-reset trap `pc_o` equals the new `tbr_o` and `npc_o` equals `tbr_o`+4. For a reset trap `pc_o` is 0 and `npc_o` is 4.
- R7: When several requests are present, reset wins over a synchronous trap, and a synchronous trap wins over an interrupt.
- R8: An interrupt is taken only when `et_i` is 1 and `irl_i` is strictly greater than `pil_i`. A level of 0 is never taken.
- R9: `pil_o` always equals the sampled `pil_i`, including when a trap is taken.
- R10: A synchronous request with `et_i` at 0 and no reset request sets `err_o`, does not assert `taken_o`, and lets all state outputs follow the inputs.
- R11: `err_o` stays set, and no trap is taken, until a reset request arrives. That reset trap is taken and clears `err_o`.
- R12: After `rst_i` every output is 0. With no request, `taken_o` is 0, the status, counter and base outputs mirror the inputs one cycle later, and the saved pair holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| et_i | input | 1 | Trap enable bit of the status word |
| s_i | input | 1 | Supervisor bit |
| ps_i | input | 1 | Previous-supervisor bit |
| cwp_i | input | 3 | Current window pointer |
| pil_i | input | 4 | Interrupt level mask |
| pc_i | input | 32 | Current program counter |
| npc_i | input | 32 | Next program counter |
| tbr_i | input | 32 | Trap base register |
| sync_req_i | input | 1 | Synchronous trap request |
| sync_tt_i | input | 8 | Type code of the synchronous trap |
| reset_req_i | input | 1 | Reset trap request |
| irl_i | input | 4 | External interrupt request level |
| et_o | output | 1 | New trap enable bit |
| s_o | output | 1 | New supervisor bit |
| ps_o | output | 1 | New previous-supervisor bit |
| cwp_o | output | 3 | New window pointer |
| pil_o | output | 4 | Interrupt level mask (unchanged) |
| pc_o | output | 32 | New program counter |
| npc_o | output | 32 | New next program counter |
| tbr_o | output | 32 | New trap base register |
| save_pc_o | output | 32 | First value to save in the new window |
| save_npc_o | output | 32 | Second value to save in the new window |
| taken_o | output | 1 | Pulses for one cycle when a trap was taken |
| err_o | output | 1 | Sticky error mode flag |

## Verification
The assertions compare each registered output with the inputs sampled one edge earlier. They therefore assume the inputs hold one value per cycle and that `rst_i` is held across at least one edge. The interrupt gating check assumes that a taken trap with neither reset nor synchronous request must be an interrupt. The bench changes every input only just after a rising edge and samples only after the following edge. Requests are applied for a single cycle, so each taken trap can be traced to exactly one set of sampled inputs.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_IRQ   = 2'd1,
    SRC_SYNC  = 2'd2,
    SRC_RESET = 2'd3
  } trap_src_e;

  localparam int unsigned TT_W = 8;

  localparam logic [TT_W-1:0] TT_RESET    = 8'h00;
  localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;

  typedef struct packed {
    trap_src_e       src;
    logic            take;
    logic            to_err;
    logic [TT_W-1:0] tt;
  } trap_decision_t;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             et_i,
  input  logic             err_i,
  input  logic             reset_req_i,
  input  logic             sync_req_i,
  input  logic [TT_W-1:0]  sync_tt_i,
  input  logic [IRQ_W-1:0] irl_i,
  input  logic [IRQ_W-1:0] pil_i,
  output trap_decision_t   dec_o
);

  logic irq_ok;

  // Strictly above the mask; level 0 can never pass.
  assign irq_ok = et_i && !err_i && (irl_i > pil_i);

  always_comb begin
    dec_o        = '0;
    dec_o.src    = SRC_NONE;
    if (reset_req_i) begin
      dec_o.src  = SRC_RESET;
      dec_o.take = 1'b1;
      dec_o.tt   = TT_RESET;
    end else if (err_i) begin
      dec_o.src  = SRC_NONE;
    end else if (sync_req_i) begin
      if (et_i) begin
        dec_o.src  = SRC_SYNC;
        dec_o.take = 1'b1;
        dec_o.tt   = sync_tt_i;
      end else begin
        dec_o.to_err = 1'b1;
      end
    end else if (irq_ok) begin
      dec_o.src  = SRC_IRQ;
      dec_o.take = 1'b1;
      dec_o.tt   = TT_IRQ_BASE + TT_W'(irl_i);
    end
  end

endmodule

// File: rtl/trap_psw_edit.sv
module trap_psw_edit #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          s_i,
  input  logic [CW-1:0] cwp_i,
  output logic          et_o,
  output logic          ps_o,
  output logic [CW-1:0] cwp_o
);

  assign et_o = 1'b0;
  assign ps_o = s_i;

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      assign cwp_o = cwp_i - 1'b1;
    end else begin : g_wrap
      assign cwp_o = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - 1'b1;
    end
  endgenerate

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
  import trap_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned TT_LSB = 4,
  localparam int unsigned TT_MSB = TT_LSB + TT_W - 1
) (
  input  trap_decision_t dec_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  npc_i,
  input  logic [AW-1:0]  tbr_i,
  output logic [AW-1:0]  tbr_o,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  npc_o,
  output logic [AW-1:0]  save_pc_o,
  output logic [AW-1:0]  save_npc_o
);

  localparam logic [AW-1:0] STEP = AW'(4);

  always_comb begin
    tbr_o                  = '0;
    tbr_o[AW-1:TT_MSB+1]   = tbr_i[AW-1:TT_MSB+1];
    tbr_o[TT_MSB:TT_LSB]   = dec_i.tt;
  end

  always_comb begin
    if (dec_i.src == SRC_RESET) begin
      pc_o  = '0;
      npc_o = STEP;
    end else begin
      pc_o  = tbr_o;
      npc_o = tbr_o + STEP;
    end
  end

  // Interrupts let the current instruction finish; others restart it.
  always_comb begin
    if (dec_i.src == SRC_IRQ) begin
      save_pc_o  = npc_i;
      save_npc_o = npc_i + STEP;
    end else begin
      save_pc_o  = pc_i;
      save_npc_o = npc_i;
    end
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IRQ_W = 4,
  localparam int unsigned CW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             et_i,
  input  logic             s_i,
  input  logic             ps_i,
  input  logic [CW-1:0]    cwp_i,
  input  logic [IRQ_W-1:0] pil_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    npc_i,
  input  logic [AW-1:0]    tbr_i,
  input  logic             sync_req_i,
  input  logic [TT_W-1:0]  sync_tt_i,
  input  logic             reset_req_i,
  input  logic [IRQ_W-1:0] irl_i,
  output logic             et_o,
  output logic             s_o,
  output logic             ps_o,
  output logic [CW-1:0]    cwp_o,
  output logic [IRQ_W-1:0] pil_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    tbr_o,
  output logic [AW-1:0]    save_pc_o,
  output logic [AW-1:0]    save_npc_o,
  output logic             taken_o,
  output logic             err_o
);

  trap_decision_t dec;
  logic           ed_et, ed_ps;
  logic [CW-1:0]  ed_cwp;
  logic [AW-1:0]  v_tbr, v_pc, v_npc, v_spc, v_snpc;

  trap_arbiter #(.IRQ_W(IRQ_W)) u_arb (
    .et_i        (et_i),
    .err_i       (err_o),
    .reset_req_i (reset_req_i),
    .sync_req_i  (sync_req_i),
    .sync_tt_i   (sync_tt_i),
    .irl_i       (irl_i),
    .pil_i       (pil_i),
    .dec_o       (dec)
  );

  trap_psw_edit #(.NWIN(NWIN)) u_psw (
    .s_i   (s_i),
    .cwp_i (cwp_i),
    .et_o  (ed_et),
    .ps_o  (ed_ps),
    .cwp_o (ed_cwp)
  );

  trap_vector_calc #(.AW(AW)) u_vec (
    .dec_i      (dec),
    .pc_i       (pc_i),
    .npc_i      (npc_i),
    .tbr_i      (tbr_i),
    .tbr_o      (v_tbr),
    .pc_o       (v_pc),
    .npc_o      (v_npc),
    .save_pc_o  (v_spc),
    .save_npc_o (v_snpc)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      et_o       <= 1'b0;
      s_o        <= 1'b0;
      ps_o       <= 1'b0;
      cwp_o      <= '0;
      pil_o      <= '0;
      pc_o       <= '0;
      npc_o      <= '0;
      tbr_o      <= '0;
      save_pc_o  <= '0;
      save_npc_o <= '0;
      taken_o    <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      s_o     <= s_i;
      pil_o   <= pil_i;
      taken_o <= dec.take;
      if (dec.take) begin
        et_o       <= ed_et;
        ps_o       <= ed_ps;
        cwp_o      <= ed_cwp;
        pc_o       <= v_pc;
        npc_o      <= v_npc;
        tbr_o      <= v_tbr;
        save_pc_o  <= v_spc;
        save_npc_o <= v_snpc;
      end else begin
        et_o  <= et_i;
        ps_o  <= ps_i;
        cwp_o <= cwp_i;
        pc_o  <= pc_i;
        npc_o <= npc_i;
        tbr_o <= tbr_i;
      end
      if (dec.src == SRC_RESET) err_o <= 1'b0;
      else if (dec.to_err)      err_o <= 1'b1;
    end
  end

  assert_et_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    taken_o |-> !et_o);

  assert_ps_copy_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    taken_o |-> (ps_o == $past(s_i)) && (s_o == $past(s_i)));

  assert_cwp_wrap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    taken_o |-> cwp_o == (($past(cwp_i) == '0) ? CW'(NWIN - 1)
                                               : CW'($past(cwp_i) - 1'b1)));

  assert_vector_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (taken_o && !$past(reset_req_i)) |-> (pc_o == tbr_o) && (npc_o == tbr_o + AW'(4)));

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (taken_o && !$past(reset_req_i) && !$past(sync_req_i))
      |-> $past(et_i) && ($past(irl_i) > $past(pil_i)));

  assert_mask_kept_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    taken_o |-> pil_o == $past(pil_i));

  assert_err_no_trap_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(err_o) |-> !taken_o);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_o && !reset_req_i) |=> (err_o && !taken_o));

endmodule

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        et_i, s_i, ps_i;
  logic [2:0]  cwp_i;
  logic [3:0]  pil_i, irl_i;
  logic [31:0] pc_i, npc_i, tbr_i;
  logic        sync_req_i, reset_req_i;
  logic [7:0]  sync_tt_i;
  logic        et_o, s_o, ps_o, taken_o, err_o;
  logic [2:0]  cwp_o;
  logic [3:0]  pil_o;
  logic [31:0] pc_o, npc_o, tbr_o, save_pc_o, save_npc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trap_entry_ctrl u0 (
    .clk_i(clk), .rst_i(rst), .et_i(et_i), .s_i(s_i), .ps_i(ps_i),
    .cwp_i(cwp_i), .pil_i(pil_i), .pc_i(pc_i), .npc_i(npc_i), .tbr_i(tbr_i),
    .sync_req_i(sync_req_i), .sync_tt_i(sync_tt_i), .reset_req_i(reset_req_i),
    .irl_i(irl_i), .et_o(et_o), .s_o(s_o), .ps_o(ps_o), .cwp_o(cwp_o),
    .pil_o(pil_o), .pc_o(pc_o), .npc_o(npc_o), .tbr_o(tbr_o),
    .save_pc_o(save_pc_o), .save_npc_o(save_npc_o), .taken_o(taken_o), .err_o(err_o)
  );

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] TBR_RAW = 32'h4000_0FF7;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    et_i = 1'b1; s_i = 1'b1; ps_i = 1'b0; cwp_i = 3'd5; pil_i = 4'd3;
    pc_i = 32'h0000_0100; npc_i = 32'h0000_0104; tbr_i = TBR_RAW;
    sync_req_i = 1'b0; sync_tt_i = 8'h00; reset_req_i = 1'b0; irl_i = 4'd0;
  endtask

  task automatic t_reset_state();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    chk("R12", "pc after rst", pc_o, 32'h0);
    chk("R12", "tbr after rst", tbr_o, 32'h0);
    chk("R12", "taken after rst", {31'b0, taken_o}, 32'h0);
    chk("R12", "err after rst", {31'b0, err_o}, 32'h0);
    chk("R12", "save after rst", save_pc_o, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_idle_mirror();
    idle_inputs();
    ps_i = 1'b1; cwp_i = 3'd2; pc_i = 32'h0000_2000; npc_i = 32'h0000_2004;
    step();
    chk("R12", "taken idle", {31'b0, taken_o}, 32'h0);
    chk("R12", "pc mirror", pc_o, 32'h0000_2000);
    chk("R12", "tbr mirror", tbr_o, TBR_RAW);
    chk("R12", "cwp/ps/et mirror", {27'b0, et_o, ps_o, cwp_o}, {27'b0, 1'b1, 1'b1, 3'd2});
    chk("R12", "save holds", save_pc_o, 32'h0);
  endtask

  task automatic t_irq_taken();
    idle_inputs();
    irl_i = 4'd9;
    step();
    irl_i = 4'd0;
    chk("R8", "irq taken", {31'b0, taken_o}, 32'h1);
    chk("R1", "et cleared", {31'b0, et_o}, 32'h0);
    chk("R2", "ps from s", {30'b0, ps_o, s_o}, 32'h3);
    chk("R3", "cwp down", {29'b0, cwp_o}, 32'd4);
    chk("R9", "pil kept", {28'b0, pil_o}, 32'd3);
    chk("R5", "tbr tt irq", tbr_o, BASE | 32'h190);
    chk("R6", "pc vector", pc_o, BASE | 32'h190);
    chk("R6", "npc vector", npc_o, BASE | 32'h194);
    chk("R4", "save pc irq", save_pc_o, 32'h0000_0104);
    chk("R4", "save npc irq", save_npc_o, 32'h0000_0108);
    step();
    chk("R4", "save holds after", save_npc_o, 32'h0000_0108);
  endtask

  task automatic t_irq_masked();
    idle_inputs();
    pil_i = 4'd5; irl_i = 4'd5;
    step();
    chk("R8", "equal level ignored", {31'b0, taken_o}, 32'h0);
    pil_i = 4'd0; irl_i = 4'd0;
    step();
    chk("R8", "level 0 ignored", {31'b0, taken_o}, 32'h0);
    et_i = 1'b0; irl_i = 4'd12;
    step();
    chk("R8", "et=0 irq ignored", {31'b0, taken_o}, 32'h0);
    chk("R8", "et=0 no error", {31'b0, err_o}, 32'h0);
    et_i = 1'b1; pil_i = 4'd14; irl_i = 4'd15;
    step();
    chk("R8", "15 over 14 taken", {31'b0, taken_o}, 32'h1);
    chk("R5", "tt 0x1f", tbr_o, BASE | 32'h1F0);
    irl_i = 4'd0;
  endtask

  task automatic t_sync_wrap();
    idle_inputs();
    s_i = 1'b0; ps_i = 1'b1; cwp_i = 3'd0; sync_req_i = 1'b1; sync_tt_i = 8'h2A;
    irl_i = 4'd15; pil_i = 4'd0;
    pc_i = 32'h0000_3000; npc_i = 32'h0000_3004;
    step();
    sync_req_i = 1'b0; irl_i = 4'd0;
    chk("R7", "sync beats irq tt", tbr_o, BASE | 32'h2A0);
    chk("R3", "cwp wraps to 7", {29'b0, cwp_o}, 32'd7);
    chk("R2", "ps from s=0", {31'b0, ps_o}, 32'h0);
    chk("R4", "save pc sync", save_pc_o, 32'h0000_3000);
    chk("R4", "save npc sync", save_npc_o, 32'h0000_3004);
    chk("R6", "npc sync", npc_o, BASE | 32'h2A4);
  endtask

  task automatic t_reset_trap();
    idle_inputs();
    reset_req_i = 1'b1; sync_req_i = 1'b1; sync_tt_i = 8'h33; irl_i = 4'd15; pil_i = 4'd0;
    step();
    reset_req_i = 1'b0; sync_req_i = 1'b0; irl_i = 4'd0;
    chk("R7", "reset taken", {31'b0, taken_o}, 32'h1);
    chk("R5", "reset tt", tbr_o, BASE);
    chk("R6", "reset pc", pc_o, 32'h0);
    chk("R6", "reset npc", npc_o, 32'h4);
    chk("R4", "save reset", save_pc_o, 32'h0000_0100);
  endtask

  task automatic t_error_mode();
    idle_inputs();
    et_i = 1'b0; sync_req_i = 1'b1; sync_tt_i = 8'h07; pc_i = 32'h0000_5000;
    step();
    sync_req_i = 1'b0;
    chk("R10", "err set", {31'b0, err_o}, 32'h1);
    chk("R10", "no trap", {31'b0, taken_o}, 32'h0);
    chk("R10", "pc passes", pc_o, 32'h0000_5000);
    chk("R10", "tbr passes", tbr_o, TBR_RAW);
    et_i = 1'b1; irl_i = 4'd15; pil_i = 4'd0;
    step();
    chk("R11", "irq blocked", {31'b0, taken_o}, 32'h0);
    chk("R11", "err sticky", {31'b0, err_o}, 32'h1);
    irl_i = 4'd0; sync_req_i = 1'b1;
    step();
    sync_req_i = 1'b0;
    chk("R11", "sync blocked", {31'b0, taken_o}, 32'h0);
    reset_req_i = 1'b1;
    step();
    reset_req_i = 1'b0;
    chk("R11", "reset taken in err", {31'b0, taken_o}, 32'h1);
    chk("R11", "err cleared", {31'b0, err_o}, 32'h0);
    chk("R11", "reset pc", pc_o, 32'h0);
  endtask

  initial begin : watchdog
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle_inputs();
    t_reset_state();
    t_idle_mirror();
    t_irq_taken();
    t_irq_masked();
    t_sync_wrap();
    t_reset_trap();
    t_error_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule